// File: doc/BRIEF.md
# Recirculating Text-Mode Address Generator

This block produces the character-memory address for a text-mode raster when no programmable display controller is present. The address is split into two parts at a page boundary. A small page counter covers the low bits and steps once per character fetch. An upper counter takes the carry out of each page. The row start address is not kept in a base register. At the end of the active area on the last scanline of a character row, the upper bits of the running address are captured into a holding latch. At every line start, both counters are reloaded from that latch. Every scanline of a row therefore fetches the same characters, and the next row begins at the character that follows.

A build parameter selects the line width. The narrow mode has 40 characters per line and 8-byte pages. The wide mode has 80 characters per line and 16-byte pages. The reload at line start and the latch capture happen on different clock edges, so the feedback loop never reads a value on the same edge that it writes it. Sync generation, glyph lookup, pixel shifting and memory arbitration sit outside this block.

Top module: `vid_recirc_addr`

## Requirements
- R1: After reset, `char_addr` is 0.
- R2: When `frame_start` is high at a clock edge, the counters and the latch clear. `char_addr` reads 0 after that edge, and the next line start loads 0. `frame_start` has priority over every other input.
- R3: When `active_en` is high and neither `frame_start` nor `line_start` is high, `char_addr` increments by exactly 1 at each clock edge.
- R4: When `active_en`, `line_start` and `frame_start` are all low, `char_addr` holds its value. This covers blanking and pauses in the middle of a line.
- R5: When `line_start` is high, the next address is the latch value in the upper bits and zero in the page bits. On a scanline that is not the last of its row, a line repeats the addresses of the line before it.
- R6: When the page bits roll over from all ones to zero, the upper counter increments by one. The address therefore runs without a gap across page boundaries: 8-byte pages in narrow mode, 16-byte pages in wide mode.
- R7: On the last scanline of a row (`scan_idx` equal to ROW_LINES-1), the first clock edge with `active_en` low after active stores the running address in the latch. The next row then starts at the previous row start plus the line width.
- R8: If the stored value would equal ROWS × line width, the latch stores 0 instead. The row after the last row of the screen starts at address 0.
- R9: With `WIDE`=1 the line width is 80 and the page is 16 bytes. With `WIDE`=0 the line width is 40 and the page is 8 bytes. Row starts step by the line width.
- R10: `line_start` has priority over `active_en`. If both are high, the edge performs the reload and does not increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Active-low reset |
| frame_start | input | 1 | Clears latch and counters to address 0 |
| line_start | input | 1 | Reloads counters from the latch before the active area |
| active_en | input | 1 | Active display; address steps while high |
| scan_idx | input | SCAN_W | Scanline number within the character row |
| char_addr | output | ADDR_W | Character memory address |

## Verification
The bench builds two copies of the block, each with 2 scanlines per row, 3 rows per screen and an 8-bit address. One copy runs in narrow mode and the other in wide mode. With screens this small, every address of every line of a whole frame is compared against arithmetic expectations. This includes every page rollover and the row that follows the last row of the screen. Mid-line pauses, a reload that overlaps an active cycle, and a frame clear issued part way through a frame are also within reach.

// File: rtl/vra_pkg.sv
package vra_pkg;

    typedef enum logic [1:0] {
        CMD_HOLD  = 2'd0,
        CMD_STEP  = 2'd1,
        CMD_LOAD  = 2'd2,
        CMD_CLEAR = 2'd3
    } vra_cmd_e;

endpackage

// File: rtl/vra_page_ctr.sv
module vra_page_ctr
    import vra_pkg::*;
#(
    parameter int PB = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  vra_cmd_e      cmd,
    output logic [PB-1:0] lo_q,
    output logic          carry
);

    typedef struct packed {
        logic [PB-1:0] lo;
    } page_st_t;

    page_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (cmd)
            CMD_CLEAR, CMD_LOAD: st_d.lo = '0;
            CMD_STEP:            st_d.lo = st_q.lo + 1'b1;
            default:             st_d    = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lo_q  = st_q.lo;
    assign carry = (cmd == CMD_STEP) && (&st_q.lo);

    // R6: a rollover leaves the page bits at zero
    p_page_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        carry |=> (lo_q == '0));

    // R3: a step without rollover adds one to the page bits
    p_page_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_STEP && !carry) |=> (lo_q == $past(lo_q) + 1'b1));

endmodule

// File: rtl/vra_upper_ctr.sv
module vra_upper_ctr
    import vra_pkg::*;
#(
    parameter int UW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  vra_cmd_e      cmd,
    input  logic          carry,
    input  logic [UW-1:0] load_val,
    output logic [UW-1:0] up_q
);

    typedef struct packed {
        logic [UW-1:0] up;
    } upper_st_t;

    upper_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (cmd)
            CMD_CLEAR: st_d.up = '0;
            CMD_LOAD:  st_d.up = load_val;
            CMD_STEP:  if (carry) st_d.up = st_q.up + 1'b1;
            default:   st_d    = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign up_q = st_q.up;

    // R6: upper bits move only on a page rollover while stepping
    p_up_needs_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_STEP && !carry) |=> $stable(up_q));

    // R4: no command means no change
    p_up_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_HOLD) |=> $stable(up_q));

endmodule

// File: rtl/vra_row_latch.sv
module vra_row_latch #(
    parameter int UW        = 8,
    parameter int SCAN_W    = 3,
    parameter int LAST_SCAN = 7,
    parameter int END_UP    = 125
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              active_en,
    input  logic [SCAN_W-1:0] scan_idx,
    input  logic [UW-1:0]     up_in,
    output logic [UW-1:0]     latch_q
);

    localparam logic [SCAN_W-1:0] LAST_IDX = SCAN_W'(LAST_SCAN);
    localparam logic [UW-1:0]     END_VAL  = UW'(END_UP);

    typedef struct packed {
        logic          act;
        logic [UW-1:0] base;
    } latch_st_t;

    latch_st_t st_d, st_q;
    logic      row_end;

    assign row_end = st_q.act && !active_en && (scan_idx == LAST_IDX);

    always_comb begin
        st_d     = st_q;
        st_d.act = active_en;
        if (frame_start) begin
            st_d.act  = 1'b0;
            st_d.base = '0;
        end else if (row_end) begin
            st_d.base = (up_in == END_VAL) ? '0 : up_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign latch_q = st_q.base;

    // R5: outside a row end the latch keeps the row start
    p_latch_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && !row_end) |=> $stable(latch_q));

    // R8: capturing the screen end address wraps to zero
    p_latch_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && row_end && up_in == END_VAL) |=> (latch_q == '0));

    // R2: frame start clears the latch
    p_latch_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (latch_q == '0));

endmodule

// File: rtl/vid_recirc_addr.sv
module vid_recirc_addr
    import vra_pkg::*;
#(
    parameter bit WIDE      = 1'b0,
    parameter int ADDR_W    = 11,
    parameter int ROW_LINES = 8,
    parameter int ROWS      = 25,
    parameter int SCAN_W    = (ROW_LINES > 1) ? $clog2(ROW_LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              line_start,
    input  logic              active_en,
    input  logic [SCAN_W-1:0] scan_idx,
    output logic [ADDR_W-1:0] char_addr
);

    localparam int PB     = WIDE ? 4 : 3;
    localparam int COLS   = WIDE ? 80 : 40;
    localparam int UW     = ADDR_W - PB;
    localparam int END_UP = (ROWS * COLS) >> PB;

    vra_cmd_e      cmd;
    logic [PB-1:0] lo_q;
    logic [UW-1:0] up_q;
    logic [UW-1:0] latch_q;
    logic          carry;

    always_comb begin
        if (frame_start)     cmd = CMD_CLEAR;
        else if (line_start) cmd = CMD_LOAD;
        else if (active_en)  cmd = CMD_STEP;
        else                 cmd = CMD_HOLD;
    end

    vra_page_ctr #(.PB(PB)) u_page (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd   (cmd),
        .lo_q  (lo_q),
        .carry (carry)
    );

    vra_upper_ctr #(.UW(UW)) u_upper (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .carry    (carry),
        .load_val (latch_q),
        .up_q     (up_q)
    );

    vra_row_latch #(
        .UW        (UW),
        .SCAN_W    (SCAN_W),
        .LAST_SCAN (ROW_LINES - 1),
        .END_UP    (END_UP)
    ) u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .active_en   (active_en),
        .scan_idx    (scan_idx),
        .up_in       (up_q),
        .latch_q     (latch_q)
    );

    assign char_addr = {up_q, lo_q};

    // R2: frame start yields address zero
    p_frame_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (char_addr == '0));

    // R3: one increment per active cycle
    p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (active_en && !line_start && !frame_start)
        |=> (char_addr == ADDR_W'($past(char_addr) + 1'b1)));

    // R4: address holds during blanking
    p_blank_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_en && !line_start && !frame_start) |=> $stable(char_addr));

    // R5 / R10: reload from latch, page bits zero, regardless of active_en
    p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && !frame_start)
        |=> (char_addr[PB-1:0] == '0 && char_addr[ADDR_W-1:PB] == $past(latch_q)));

endmodule

// File: tb/test_vid_recirc_addr.sv
module test_vid_recirc_addr;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] fs = '0, ls = '0, ae = '0, sc = '0;
    logic [7:0] addr [2];

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    vid_recirc_addr #(.WIDE(1'b0), .ADDR_W(8), .ROW_LINES(2), .ROWS(3)) i_vid_recirc_addr (
        .clk(clk), .rst_n(rst_n), .frame_start(fs[0]), .line_start(ls[0]),
        .active_en(ae[0]), .scan_idx(sc[0:0]), .char_addr(addr[0]));

    vid_recirc_addr #(.WIDE(1'b1), .ADDR_W(8), .ROW_LINES(2), .ROWS(3)) i_vid_recirc_addr_w (
        .clk(clk), .rst_n(rst_n), .frame_start(fs[1]), .line_start(ls[1]),
        .active_en(ae[1]), .scan_idx(sc[1:1]), .char_addr(addr[1]));

    task automatic check(input string req, input int d, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s dut%0d: actual %0d expected %0d", req, d, act, exp);
        end
    endtask

    function automatic int cols_of(input int d);
        return (d == 1) ? 80 : 40;
    endfunction

    task automatic pulse_frame(input int d);
        @(negedge clk); fs[d] = 1'b1;
        @(negedge clk); fs[d] = 1'b0;
        check("R2", d, int'(addr[d]), 0);
    endtask

    // one scanline: reload, active run, blanking tail
    task automatic do_line(input int d, input int s, input int base, input string base_req,
                           input bit pause, input bit overlap);
        int cols = cols_of(d);
        int pg   = (d == 1) ? 16 : 8;
        @(negedge clk); ls[d] = 1'b1; sc[d] = s[0]; if (overlap) ae[d] = 1'b1;
        @(negedge clk); ls[d] = 1'b0; ae[d] = 1'b1;
        check(base_req, d, int'(addr[d]), base);
        for (int c = 0; c < cols; c++) begin
            if (c > 0 && ((base + c) % pg) == 0) check("R6", d, int'(addr[d]), base + c);
            else                                check("R3", d, int'(addr[d]), base + c);
            if (pause && c == 5) begin
                ae[d] = 1'b0;
                for (int k = 0; k < 2; k++) begin
                    @(negedge clk);
                    check("R4", d, int'(addr[d]), base + c);
                end
                ae[d] = 1'b1;
            end
            @(negedge clk);
        end
        check("R3", d, int'(addr[d]), base + cols);
        ae[d] = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R4", d, int'(addr[d]), base + cols);
        end
    endtask

    task automatic do_rows(input int d, input int nrows);
        int cols = cols_of(d);
        for (int r = 0; r < nrows; r++) begin
            for (int s = 0; s < 2; s++) begin
                int    base = (r % 3) * cols;
                string tag;
                if (s == 1)         tag = "R5";
                else if (r == 3)    tag = "R8";
                else if (r > 0)     tag = (d == 1) ? "R9" : "R7";
                else                tag = "R2";
                if (r == 1 && s == 0) tag = "R10";
                do_line(d, s, base, tag, (r == 0 && s == 0), (r == 1 && s == 0));
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", 0, int'(addr[0]), 0);
        check("R1", 1, int'(addr[1]), 0);
        rst_n = 1'b1;
        for (int d = 0; d < 2; d++) begin
            pulse_frame(d);
            do_rows(d, 4);          // rows 0..2 then wrap to row 0 (R8)
            pulse_frame(d);         // latch held row 1 start; clear it
            do_line(d, 0, 0, "R2", 1'b0, 1'b0);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule